// File: doc/BRIEF.md
# Five-Channel Countdown Timer Bank

The block holds five down-counters with a shared control word. Each counter has a count buffer that software preloads. A rising edge on the counter's manual-update control bit copies that buffer into the live counter. The counter then decrements on its own tick strobe, which a separate prescaler supplies, for as long as its start bit stays set.

When a counter runs out, the block sends a one-cycle expire pulse toward the interrupt logic. The counter then either refills itself from its buffer and keeps running, or it stops and hardware clears its start bit. Timers 0 to 3 also have a compare buffer and a waveform output. That output toggles when a decrement lands on the compare value, and a per-timer invert bit can flip it. Timer 4 has no compare buffer, no invert bit and no waveform output.

Software reaches the block through a simple word register port. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `tmr_bank`

## Requirements
- R1: After reset, the control word, every count buffer, every compare buffer and every live count read as zero, and `expire_o` and `pwm_o` are low.
- R2: A write to offset 0x08 stores the whole 32-bit value, and reads of 0x08 return it. Each timer has a group of control bits:
  - Timer 0: start bit 0, manual-update bit 1, invert bit 2, reload bit 3.
  - Timer n (n = 1 to 3): the same four bits starting at bit 4+4n, that is at bits 8, 12 and 16.
  - Timer 4: start bit 20, manual-update bit 21, reload bit 22.
- R3: A control write that takes a timer's manual-update bit from 0 to 1 loads that timer's count buffer into its live count. A write that leaves the bit at 1 does not reload.
- R4: A timer counts only while its start bit is 1. Setting the bit starts the timer, and clearing it stops the timer. A stopped timer keeps its count.
- R5: Each tick on `tick_i[n]` while timer n runs lowers its count by one, as long as the count is above 1.
- R6: A tick on a running timer whose count is 1 or 0 is an expiry. `expire_o[n]` is high for exactly the one cycle after that clock edge.
- R7: On expiry with the reload bit set, the count takes the count buffer value and the start bit stays 1.
- R8: On expiry with the reload bit clear, the count becomes 0 and hardware clears the timer's start bit in the control word.
- R9: Address map. Count buffer n is at 0x0C+0xC·n for n = 0 to 4. Compare buffer n is at 0x10+0xC·n for n = 0 to 3. The live count of timer n is at 0x14+0xC·n for n = 0 to 3, and timer 4's live count is at 0x40. Buffers read back the last value written, and live-count reads return the current count.
- R10: Any other offset, including misaligned offsets, reads as zero and ignores writes. Writes to live-count offsets change nothing.
- R11: For n = 0 to 3, an internal level toggles whenever a tick decrement makes the count equal compare buffer n. `pwm_o[n]` is that level XOR the timer's invert bit. No other event changes the level.
- R12: In a cycle that writes the control word, all ticks are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the register port |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| tick_i | input | 5 | Per-timer decrement strobe from the prescaler |
| expire_o | output | 5 | Per-timer one-cycle expiry pulse |
| pwm_o | output | 4 | Waveform outputs of timers 0 to 3 |

## Verification
The assertions check these relations on every cycle:
- A stopped timer holds its count.
- A qualified tick lowers the count by exactly one.
- An expire pulse always follows a tick.
- On expiry, the count and the start bit match the reload bit that was in effect.
- A control write is stored whole.
- A waveform output stays steady in cycles with no tick.

Only the bench's scenarios can show the following:
- The edge behaviour of manual update: a held bit does not reload.
- The irregular bit layout of timer 4.
- The address decode, including misaligned and read-only offsets.
- The waveform toggle landing exactly on the compare value.
- How these interact under a random mix of writes and ticks.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;
  localparam int unsigned NUM_TMR = 5;
  localparam int unsigned NUM_PWM = NUM_TMR - 1;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned IDX_W   = $clog2(REG_W);
  localparam int unsigned CTL_OFF = 8;
  localparam int unsigned STRIDE  = 12;

  typedef logic [IDX_W-1:0] bit_idx_t;

  // control group base: timer 0 at bit 0, timer n>0 at bit 4+4n
  function automatic bit_idx_t f_base(int unsigned t);
    return bit_idx_t'((t == 0) ? 0 : 4 + 4 * t);
  endfunction
  function automatic bit_idx_t f_start(int unsigned t);
    return f_base(t);
  endfunction
  function automatic bit_idx_t f_manual(int unsigned t);
    return f_base(t) + bit_idx_t'(1);
  endfunction
  function automatic bit_idx_t f_invert(int unsigned t);
    return f_base(t) + bit_idx_t'(2);
  endfunction
  // timer without inverter packs reload into the inverter slot
  function automatic bit_idx_t f_reload(int unsigned t);
    return f_base(t) + bit_idx_t'((t < NUM_PWM) ? 3 : 2);
  endfunction

  function automatic int unsigned f_cntb_off(int unsigned t);
    return 12 + STRIDE * t;
  endfunction
  function automatic int unsigned f_cmpb_off(int unsigned t);
    return 16 + STRIDE * t;
  endfunction
  function automatic int unsigned f_obs_off(int unsigned t);
    return (t < NUM_PWM) ? 20 + STRIDE * t : f_cntb_off(t) + 4;
  endfunction
endpackage

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 32
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [REG_W-1:0]                  wdata_i,
  output logic [REG_W-1:0]                  rdata_o,
  input  logic [NUM_TMR-1:0][CNT_W-1:0]     cnt_i,
  input  logic [NUM_TMR-1:0]                stop_i,
  output logic [REG_W-1:0]                  ctrl_o,
  output logic                              ctrl_wr_o,
  output logic [NUM_TMR-1:0]                run_o,
  output logic [NUM_TMR-1:0]                reload_o,
  output logic [NUM_TMR-1:0]                load_o,
  output logic [NUM_PWM-1:0]                inv_o,
  output logic [NUM_TMR-1:0][CNT_W-1:0]     cntb_o,
  output logic [NUM_PWM-1:0][CNT_W-1:0]     cmpb_o
);
  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] clr_mask;
  logic             ctrl_wr;

  assign ctrl_wr   = we_i && (addr_i == ADDR_W'(CTL_OFF));
  assign ctrl_wr_o = ctrl_wr;
  assign ctrl_o    = ctrl_q;

  always_comb begin
    clr_mask = '0;
    for (int t = 0; t < NUM_TMR; t++) begin
      if (stop_i[t]) clr_mask[f_start(t)] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wdata_i;
    else              ctrl_q <= ctrl_q & ~clr_mask;
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    assign run_o[t]    = ctrl_q[f_start(t)];
    assign reload_o[t] = ctrl_q[f_reload(t)];
    // manual update acts on the 0->1 edge only
    assign load_o[t]   = ctrl_wr && wdata_i[f_manual(t)] && !ctrl_q[f_manual(t)];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cntb_o[t] <= '0;
      else if (we_i && addr_i == ADDR_W'(f_cntb_off(t))) cntb_o[t] <= wdata_i[CNT_W-1:0];
    end
  end

  for (genvar t = 0; t < NUM_PWM; t++) begin : g_cmp
    assign inv_o[t] = ctrl_q[f_invert(t)];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cmpb_o[t] <= '0;
      else if (we_i && addr_i == ADDR_W'(f_cmpb_off(t))) cmpb_o[t] <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(CTL_OFF)) rdata_o = ctrl_q;
    for (int t = 0; t < NUM_TMR; t++) begin
      if (addr_i == ADDR_W'(f_cntb_off(t))) rdata_o = REG_W'(cntb_o[t]);
      if (addr_i == ADDR_W'(f_obs_off(t)))  rdata_o = REG_W'(cnt_i[t]);
    end
    for (int t = 0; t < NUM_PWM; t++) begin
      if (addr_i == ADDR_W'(f_cmpb_off(t))) rdata_o = REG_W'(cmpb_o[t]);
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic             run_i,
  input  logic             reload_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] buf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o,
  output logic             stop_o,
  output logic             dec_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             fire, hit;

  assign fire   = tick_i && run_i && !hold_i;
  assign hit    = fire && (cnt_q <= CNT_W'(1));
  assign dec_o  = fire && !hit;
  assign stop_o = hit && !reload_i;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= hit;
      if (load_i)     cnt_q <= buf_i;
      else if (hit)   cnt_q <= reload_i ? buf_i : '0;
      else if (dec_o) cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             inv_i,
  output logic             pwm_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else if (step_i && (cnt_i - CNT_W'(1)) == cmp_i) lvl_q <= ~lvl_q;
  end

  assign pwm_o = lvl_q ^ inv_i;
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  input  logic [NUM_TMR-1:0] tick_i,
  output logic [NUM_TMR-1:0] expire_o,
  output logic [NUM_PWM-1:0] pwm_o
);
  logic [REG_W-1:0]              ctrl_q;
  logic                          ctrl_wr;
  logic [NUM_TMR-1:0]            run, reload, load_p, stop, dec;
  logic [NUM_PWM-1:0]            inv;
  logic [NUM_TMR-1:0][CNT_W-1:0] cnt, cntb;
  logic [NUM_PWM-1:0][CNT_W-1:0] cmpb;

  tmr_regif #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regif (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .cnt_i     (cnt),
    .stop_i    (stop),
    .ctrl_o    (ctrl_q),
    .ctrl_wr_o (ctrl_wr),
    .run_o     (run),
    .reload_o  (reload),
    .load_o    (load_p),
    .inv_o     (inv),
    .cntb_o    (cntb),
    .cmpb_o    (cmpb)
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_ch
    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i[t]),
      .hold_i   (ctrl_wr),
      .run_i    (run[t]),
      .reload_i (reload[t]),
      .load_i   (load_p[t]),
      .buf_i    (cntb[t]),
      .cnt_o    (cnt[t]),
      .expire_o (expire_o[t]),
      .stop_o   (stop[t]),
      .dec_o    (dec[t])
    );
  end

  for (genvar t = 0; t < NUM_PWM; t++) begin : g_pwm
    tmr_pwm #(.CNT_W(CNT_W)) u_pwm (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (dec[t]),
      .cnt_i  (cnt[t]),
      .cmp_i  (cmpb[t]),
      .inv_i  (inv[t]),
      .pwm_o  (pwm_o[t])
    );
  end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
  import tmr_bank_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [REG_W-1:0]              wdata_i,
  input logic [NUM_TMR-1:0]            tick_i,
  input logic [NUM_TMR-1:0]            expire_o,
  input logic [NUM_PWM-1:0]            pwm_o,
  input logic [REG_W-1:0]              ctrl_i,
  input logic                          ctrl_wr_i,
  input logic [NUM_TMR-1:0][CNT_W-1:0] cnt_i,
  input logic [NUM_TMR-1:0][CNT_W-1:0] cntb_i,
  input logic [NUM_TMR-1:0]            load_i,
  input logic [NUM_TMR-1:0]            dec_i
);
  p_ctrl_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> ctrl_i == $past(wdata_i));

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_t
    p_hold_stopped_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctrl_i[f_start(t)] && !load_i[t] |=> $stable(cnt_i[t]));

    p_dec_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_i[f_start(t)] && tick_i[t] && !ctrl_wr_i && cnt_i[t] > CNT_W'(1)
      |=> cnt_i[t] == $past(cnt_i[t]) - CNT_W'(1));

    p_expire_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_o[t] |-> $past(tick_i[t]) && !$past(ctrl_wr_i));

    p_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_o[t] && $past(ctrl_i[f_reload(t)])
      |-> cnt_i[t] == $past(cntb_i[t]) && ctrl_i[f_start(t)]);

    p_autostop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_o[t] && !$past(ctrl_i[f_reload(t)])
      |-> cnt_i[t] == '0 && !ctrl_i[f_start(t)]);

    p_step_gate_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dec_i[t] |-> tick_i[t] && !ctrl_wr_i && ctrl_i[f_start(t)]);
  end

  for (genvar t = 0; t < NUM_PWM; t++) begin : g_p
    p_pwm_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i[t] && !ctrl_wr_i |=> $stable(pwm_o[t]));
  end
endmodule

bind tmr_bank tmr_bank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wdata_i   (wdata_i),
  .tick_i    (tick_i),
  .expire_o  (expire_o),
  .pwm_o     (pwm_o),
  .ctrl_i    (ctrl_q),
  .ctrl_wr_i (ctrl_wr),
  .cnt_i     (cnt),
  .cntb_i    (cntb),
  .load_i    (load_p),
  .dec_i     (dec)
);

// File: tb/tmr_bank_tb.sv
module tmr_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 5;
  localparam int NP = 4;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        we;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic [4:0]  tick, expire;
  logic [3:0]  pwm;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_bank u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .tick_i(tick), .expire_o(expire), .pwm_o(pwm)
  );

  // control bit positions per R2
  int b_st[NT]  = '{0, 8, 12, 16, 20};
  int b_man[NT] = '{1, 9, 13, 17, 21};
  int b_inv[NP] = '{2, 10, 14, 18};
  int b_rl[NT]  = '{3, 11, 15, 19, 22};

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_ctrl;
  logic [31:0] m_cnt[NT];
  logic [31:0] m_cntb[NT];
  logic [31:0] m_cmpb[NP];
  logic        m_lvl[NP];
  logic [4:0]  m_exp;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] v = '0;
    if (a == 8'd8) v = m_ctrl;
    for (int t = 0; t < NT; t++) begin
      if (a == 8'(12 + 12 * t)) v = m_cntb[t];
      if (a == ((t < NP) ? 8'(20 + 12 * t) : 8'd64)) v = m_cnt[t];
    end
    for (int t = 0; t < NP; t++) if (a == 8'(16 + 12 * t)) v = m_cmpb[t];
    return v;
  endfunction

  function automatic string rtag(input logic [7:0] a);
    if (a == 8'd8) return "R2 ctrl read";
    if (a >= 8'd12 && a <= 8'd64 && a[1:0] == 2'b00) return "R9 map read";
    return "R10 unmapped read";
  endfunction

  task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d, input logic [4:0] tk);
    logic [31:0] n_ctrl;
    logic [31:0] n_cnt[NT];
    logic [31:0] n_cntb[NT];
    logic [31:0] n_cmpb[NP];
    logic        n_lvl[NP];
    logic [4:0]  n_exp;
    logic        cw;
    we = w; addr = a; wdata = d; tick = tk;
    #1;
    if (!w) chk(rtag(a), rdata, m_read(a));
    cw = w && a == 8'd8;
    n_ctrl = m_ctrl;
    for (int t = 0; t < NT; t++) begin
      logic ld, fire, hit, dc;
      ld   = cw && d[b_man[t]] && !m_ctrl[b_man[t]];
      fire = tk[t] && m_ctrl[b_st[t]] && !cw;
      hit  = fire && m_cnt[t] <= 1;
      dc   = fire && !hit;
      n_exp[t] = hit;
      n_cnt[t] = ld ? m_cntb[t] : hit ? (m_ctrl[b_rl[t]] ? m_cntb[t] : 32'd0)
               : dc ? m_cnt[t] - 1 : m_cnt[t];
      if (hit && !m_ctrl[b_rl[t]]) n_ctrl[b_st[t]] = 1'b0;
      if (t < NP) begin
        n_lvl[t] = m_lvl[t] ^ (dc && (m_cnt[t] - 1) == m_cmpb[t]);
        n_cmpb[t] = (w && a == 8'(16 + 12 * t)) ? d : m_cmpb[t];
      end
      n_cntb[t] = (w && a == 8'(12 + 12 * t)) ? d : m_cntb[t];
    end
    if (cw) n_ctrl = d;
    @(posedge clk);
    m_ctrl = n_ctrl; m_exp = n_exp;
    for (int t = 0; t < NT; t++) begin
      m_cnt[t] = n_cnt[t]; m_cntb[t] = n_cntb[t];
    end
    for (int t = 0; t < NP; t++) begin
      m_lvl[t] = n_lvl[t]; m_cmpb[t] = n_cmpb[t];
    end
    @(negedge clk);
    for (int t = 0; t < NT; t++) chk("R6 expire pulse", 32'(expire[t]), 32'(m_exp[t]));
    for (int t = 0; t < NP; t++) chk("R11 pwm level", 32'(pwm[t]), 32'(m_lvl[t] ^ m_ctrl[b_inv[t]]));
  endtask

  task automatic peek(input logic [7:0] a, input string tag, input logic [31:0] exp);
    we = 1'b0; addr = a; tick = '0;
    #1;
    chk(tag, rdata, exp);
    cyc(1'b0, a, 32'd0, 5'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_ctrl = '0; m_exp = '0;
    for (int t = 0; t < NT; t++) begin m_cnt[t] = '0; m_cntb[t] = '0; end
    for (int t = 0; t < NP; t++) begin m_cmpb[t] = '0; m_lvl[t] = 1'b0; end
    we = 1'b0; addr = '0; wdata = '0; tick = '0;
    rst_ni = 1'b1;
    #1 rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 expire", 32'(expire), 32'd0);
    chk("R1 pwm", 32'(pwm), 32'd0);
    peek(8'h08, "R1 ctrl", 32'd0);
    peek(8'h0C, "R1 count buffer", 32'd0);
    peek(8'h40, "R1 live count 4", 32'd0);

    // timer 0: load, run, hold, expire and stop
    cyc(1, 8'h0C, 32'd3, 5'd0);
    cyc(1, 8'h10, 32'd1, 5'd0);
    cyc(1, 8'h08, 32'h2, 5'd0);
    peek(8'h14, "R3 manual load", 32'd3);
    cyc(1, 8'h08, 32'h1, 5'd0);
    peek(8'h14, "R4 start without tick", 32'd3);
    cyc(0, 8'h00, 32'd0, 5'h01);
    peek(8'h14, "R5 decrement", 32'd2);
    cyc(1, 8'h08, 32'h1, 5'h01);
    peek(8'h14, "R12 tick ignored on ctrl write", 32'd2);
    cyc(1, 8'h08, 32'h3, 5'd0);
    peek(8'h14, "R3 manual load while running", 32'd3);
    cyc(0, 8'h00, 32'd0, 5'h01);
    cyc(1, 8'h08, 32'h3, 5'd0);
    peek(8'h14, "R3 held manual bit no reload", 32'd2);
    cyc(0, 8'h00, 32'd0, 5'h01);
    chk("R11 toggle at compare", 32'(pwm[0]), 32'd1);
    cyc(0, 8'h00, 32'd0, 5'h01);
    chk("R6 expire timer 0", 32'(expire[0]), 32'd1);
    peek(8'h08, "R8 start bit cleared", 32'h2);
    peek(8'h14, "R8 count zero", 32'd0);
    cyc(0, 8'h00, 32'd0, 5'h01);
    peek(8'h14, "R4 stopped holds", 32'd0);

    // timer 4: irregular layout, auto-reload
    cyc(1, 8'h3C, 32'd2, 5'd0);
    cyc(1, 8'h08, 32'h0020_0000, 5'd0);
    peek(8'h40, "R3 timer 4 load", 32'd2);
    cyc(1, 8'h08, 32'h0050_0000, 5'd0);
    cyc(0, 8'h00, 32'd0, 5'h10);
    cyc(0, 8'h00, 32'd0, 5'h10);
    chk("R7 expire timer 4", 32'(expire[4]), 32'd1);
    peek(8'h40, "R7 reloaded count", 32'd2);
    peek(8'h08, "R7 start kept", 32'h0050_0000);
    cyc(0, 8'h00, 32'd0, 5'h10);
    cyc(1, 8'h08, 32'h0040_0000, 5'd0);
    cyc(0, 8'h00, 32'd0, 5'h10);
    peek(8'h40, "R4 stop holds count", 32'd1);

    // invert bit
    cyc(1, 8'h08, 32'h4, 5'd0);
    chk("R11 inverted output", 32'(pwm[0]), 32'd0);

    // unmapped and read-only offsets
    cyc(1, 8'h00, 32'hFFFF_FFFF, 5'd0);
    cyc(1, 8'h44, 32'hFFFF_FFFF, 5'd0);
    cyc(1, 8'h3E, 32'hFFFF_FFFF, 5'd0);
    cyc(1, 8'h14, 32'h55, 5'd0);
    peek(8'h00, "R10 offset 0x00", 32'd0);
    peek(8'h44, "R10 offset 0x44", 32'd0);
    peek(8'h3E, "R10 misaligned", 32'd0);
    peek(8'h14, "R10 live count read-only", 32'd0);
    peek(8'h10, "R9 compare readback", 32'd1);
    peek(8'h0C, "R9 count buffer readback", 32'd3);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [7:0] a;
      r = int'($urandom % 100);
      if (r < 12) begin
        cyc(1, 8'h08, $urandom, 5'($urandom));
      end else if (r < 32) begin
        a = 8'(12 + 4 * ($urandom % 14));
        cyc(1, a, $urandom % 6, 5'($urandom));
      end else if (r < 37) begin
        a = 8'($urandom % 8'h50);
        if (a == 8'h08) a = 8'h09;
        cyc(1, a, $urandom, 5'($urandom));
      end else begin
        cyc(0, 8'($urandom % 8'h50), 32'd0, 5'($urandom));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule